// File: doc/BRIEF.md
# Dynamic-Baseline Zero Suppressor

This block sits on a stream of 12-bit ADC samples that carries samples from several channels in turn. It drops the quiet parts of each channel's waveform. For every channel it keeps a baseline, which is the mean of the most recent quiet samples. A sample is flagged when it sits further from that baseline than a programmable threshold, above or below. When a channel produces a flagged sample, the block emits a region for it. The region opens with a header word. Next come a programmable number of samples from before the first flagged one, then the flagged samples, then a programmable tail of samples after the last flagged one. An end marker closes the region.

Both the input and the output are valid/ready streams. An input beat is taken only when `in_valid` and `in_ready` are both high at a clock edge. After the block accepts a sample that must be kept, it drops `in_ready` and stays low until every output word produced by that sample has been taken. While `out_valid` is high and `out_ready` is low, the output word holds its value. The threshold, pre-count and post-count are plain configuration pins. They are read when each sample is accepted.

Top module: `zs_dyn_suppress`

## Requirements
- R1: The baseline of a channel is computed as (S*K)>>24. S is the sum of its last 192 quiet samples and K = ceil(2^24/192). When those 192 samples are all equal, the baseline equals that value exactly.
- R2: After reset, each channel uses its first 192 accepted samples only to fill its baseline window. These samples are never flagged and produce no output.
- R3: A sample is flagged when |sample - baseline| > cfg_thresh. This works in both polarities. A difference exactly equal to the threshold is not flagged.
- R4: Flagged samples never enter the baseline window, so a long pulse does not shift the baseline.
- R5: A region opens with a header word (kind 0, data 0). The header carries the channel and the timestamp of the region's first kept sample. Next come the min(cfg_pre, n) samples that precede the flagged sample, in time order, where n is the number of quiet samples since the channel's previous kept sample. The flagged sample follows them. Kept samples use kind 1, with the sample value in out_data.
- R6: After each flagged sample, the next cfg_post quiet samples are kept. A flagged sample that arrives inside this tail restarts the tail within the same region, with no new header. With cfg_post = 0, only the flagged run is kept.
- R7: An end marker (kind 2, data 0) is emitted when the first quiet sample beyond the tail arrives. Its timestamp is that of the last kept sample. The sample that triggers it is not kept.
- R8: The timestamp of a sample is the count of that channel's samples accepted since reset, starting at 0.
- R9: While out_valid is high and out_ready is low, the output word is held. in_ready is low while the block is emitting words. After reset, in_ready is 1 and out_valid is 0.
- R10: Channels are independent: each one has its own baseline, region state and timestamp counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_thresh | input | SW | Flagging threshold in ADC counts |
| cfg_pre | input | PRE_W | Samples kept before a region |
| cfg_post | input | POST_W | Quiet samples kept after the last flagged one |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can take a sample |
| in_chan | input | CH_W | Channel of the input sample |
| in_sample | input | SW | ADC value |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer takes the word |
| out_kind | output | 2 | 0 header, 1 sample, 2 end marker |
| out_chan | output | CH_W | Channel of the word |
| out_ts | output | TS_W | Timestamp of the word |
| out_data | output | SW | Sample value (0 for header and end) |

## Verification
The in-line assertions run on every cycle. They check that an output word stays frozen under back-pressure and that a header is always followed by a sample word of the same channel. They also check that the window fill and the running sum stay in bounds, that a channel's sum changes only when a quiet sample of that channel is pushed, and that a flagged sample always leaves its channel open with a fresh tail. Only the bench scenarios can show the rest. These are the exact word sequences: the pre-sample counts when the gap since the last region is short, merged tails, deferred end markers, the edge at which the threshold is crossed in both polarities, and a baseline left unchanged by a long pulse.

// File: rtl/zs_pkg.sv
`timescale 1ns/1ps
package zs_pkg;
  typedef enum logic [1:0] {
    KIND_HDR = 2'd0,
    KIND_SMP = 2'd1,
    KIND_END = 2'd2
  } zs_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_PRE,
    ST_SMP,
    ST_END
  } zs_state_e;
endpackage

// File: rtl/zs_recip_div.sv
`timescale 1ns/1ps
// Divides a window sum by WIN using a rounded-up fixed-point reciprocal.
module zs_recip_div #(
  parameter int SUM_W = 20,
  parameter int OUT_W = 12,
  parameter int WIN   = 192
) (
  input  logic [SUM_W-1:0] sum,
  output logic [OUT_W-1:0] mean
);
  localparam int SH = SUM_W + 4;
  localparam longint unsigned KL = ((64'd1 << SH) + 64'(WIN) - 64'd1) / 64'(WIN);
  localparam logic [SH:0] K = (SH+1)'(KL);

  logic [SUM_W+SH:0] prod;
  assign prod = (SUM_W+SH+1)'(sum) * (SUM_W+SH+1)'(K);
  assign mean = OUT_W'(prod >> SH);
endmodule

// File: rtl/zs_baseline.sv
`timescale 1ns/1ps
// Per-channel sliding window of quiet samples, running sum and mean.
// The same window doubles as the store for pre-region samples.
module zs_baseline #(
  parameter int NCH   = 4,
  parameter int CH_W  = 2,
  parameter int SW    = 12,
  parameter int WIN   = 192,
  parameter int PRE_W = 4,
  parameter int SUM_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CH_W-1:0]  chan,
  output logic [SW-1:0]    base,
  output logic             warm_done,
  input  logic             push,
  input  logic [CH_W-1:0]  push_chan,
  input  logic [SW-1:0]    push_sample,
  input  logic [CH_W-1:0]  rd_chan,
  input  logic [PRE_W-1:0] rd_back,
  output logic [SW-1:0]    rd_sample
);
  localparam int IDX_W  = $clog2(WIN);
  localparam int ADDR_W = $clog2(NCH*WIN);
  localparam int FILL_W = $clog2(WIN+1);

  logic [SW-1:0]     mem  [NCH*WIN];
  logic [IDX_W-1:0]  wp   [NCH];
  logic [FILL_W-1:0] fill [NCH];
  logic [SUM_W-1:0]  sum  [NCH];

  function automatic logic [ADDR_W-1:0] addr_of(input logic [CH_W-1:0] c,
                                               input logic [IDX_W-1:0] i);
    return ADDR_W'(c) * ADDR_W'(WIN) + ADDR_W'(i);
  endfunction

  logic [SW-1:0]    oldest;
  logic             push_full;
  logic [IDX_W:0]   rd_tmp;
  logic [IDX_W-1:0] rd_idx;

  always_comb begin
    oldest    = mem[addr_of(push_chan, wp[push_chan])];
    push_full = (fill[push_chan] == FILL_W'(WIN));
    rd_tmp    = {1'b0, wp[rd_chan]} - (IDX_W+1)'(rd_back);
    if (rd_tmp[IDX_W]) rd_tmp = rd_tmp + (IDX_W+1)'(WIN);
    rd_idx    = rd_tmp[IDX_W-1:0];
    rd_sample = mem[addr_of(rd_chan, rd_idx)];
    warm_done = (fill[chan] == FILL_W'(WIN));
  end

  zs_recip_div #(.SUM_W(SUM_W), .OUT_W(SW), .WIN(WIN)) u_div (
    .sum  (sum[chan]),
    .mean (base)
  );

  always_ff @(posedge clk) begin
    if (push) mem[addr_of(push_chan, wp[push_chan])] <= push_sample;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        wp[c]   <= '0;
        fill[c] <= '0;
        sum[c]  <= '0;
      end
    end else if (push) begin
      wp[push_chan] <= (wp[push_chan] == IDX_W'(WIN-1)) ? '0 : wp[push_chan] + 1'b1;
      if (!push_full) fill[push_chan] <= fill[push_chan] + 1'b1;
      sum[push_chan] <= sum[push_chan] + SUM_W'(push_sample)
                        - (push_full ? SUM_W'(oldest) : '0);
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    assert_fill_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fill[g] <= FILL_W'(WIN));
    assert_sum_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
      sum[g] <= SUM_W'(fill[g]) * SUM_W'((1 << SW) - 1));
    assert_sum_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(push && push_chan == CH_W'(g)) |=> $stable(sum[g]));
  end
endmodule

// File: rtl/zs_region_ctl.sv
`timescale 1ns/1ps
// Per-channel region tracking: open flag, tail counter, pre-sample count
// and timestamp counter. Produces the emit decision for the current sample.
module zs_region_ctl #(
  parameter int NCH     = 4,
  parameter int CH_W    = 2,
  parameter int TS_W    = 32,
  parameter int PRE_W   = 4,
  parameter int POST_W  = 4,
  parameter int PRE_MAX = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CH_W-1:0]   chan,
  input  logic              commit,
  input  logic              warm,
  input  logic              pass,
  input  logic [PRE_W-1:0]  cfg_pre,
  input  logic [POST_W-1:0] cfg_post,
  output logic              dec_hdr,
  output logic              dec_smp,
  output logic              dec_end,
  output logic [PRE_W-1:0]  dec_npre,
  output logic [TS_W-1:0]   ts_now
);
  logic              act  [NCH];
  logic [POST_W-1:0] tail [NCH];
  logic [PRE_W-1:0]  pcnt [NCH];
  logic [TS_W-1:0]   ts   [NCH];

  logic              n_act;
  logic [POST_W-1:0] n_tail;
  logic [PRE_W-1:0]  n_pcnt, p_inc;

  always_comb begin
    n_act   = act[chan];
    n_tail  = tail[chan];
    n_pcnt  = pcnt[chan];
    dec_hdr = 1'b0;
    dec_smp = 1'b0;
    dec_end = 1'b0;
    p_inc   = (pcnt[chan] == PRE_W'(PRE_MAX)) ? pcnt[chan] : pcnt[chan] + 1'b1;
    dec_npre = (pcnt[chan] < cfg_pre) ? pcnt[chan] : cfg_pre;
    ts_now  = ts[chan];
    if (!warm) begin
      n_pcnt = p_inc;
    end else if (act[chan]) begin
      if (pass) begin
        dec_smp = 1'b1;
        n_tail  = cfg_post;
      end else if (tail[chan] != '0) begin
        dec_smp = 1'b1;
        n_tail  = tail[chan] - 1'b1;
      end else begin
        dec_end = 1'b1;
        n_act   = 1'b0;
        n_pcnt  = PRE_W'(1);
      end
    end else if (pass) begin
      dec_hdr = 1'b1;
      dec_smp = 1'b1;
      n_act   = 1'b1;
      n_tail  = cfg_post;
      n_pcnt  = '0;
    end else begin
      n_pcnt = p_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        act[c]  <= 1'b0;
        tail[c] <= '0;
        pcnt[c] <= '0;
        ts[c]   <= '0;
      end
    end else if (commit) begin
      act[chan]  <= n_act;
      tail[chan] <= n_tail;
      pcnt[chan] <= n_pcnt;
      ts[chan]   <= ts[chan] + 1'b1;
    end
  end

  assert_pass_opens_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && warm && pass) |=> act[$past(chan)] && (tail[$past(chan)] == $past(cfg_post)));
endmodule

// File: rtl/zs_dyn_suppress.sv
`timescale 1ns/1ps
// Top: threshold test, emit sequencer and valid/ready edges.
module zs_dyn_suppress
  import zs_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int SW     = 12,
  parameter int WIN    = 192,
  parameter int TS_W   = 32,
  parameter int PRE_W  = 4,
  parameter int POST_W = 4,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SW-1:0]     cfg_thresh,
  input  logic [PRE_W-1:0]  cfg_pre,
  input  logic [POST_W-1:0] cfg_post,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CH_W-1:0]   in_chan,
  input  logic [SW-1:0]     in_sample,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_kind,
  output logic [CH_W-1:0]   out_chan,
  output logic [TS_W-1:0]   out_ts,
  output logic [SW-1:0]     out_data
);
  localparam int SUM_W   = SW + $clog2(WIN+1);
  localparam int PRE_MAX = (1 << PRE_W) - 1;

  zs_state_e        st;
  logic [CH_W-1:0]  r_chan;
  logic [TS_W-1:0]  r_ts;
  logic [SW-1:0]    r_sample;
  logic [PRE_W-1:0] r_npre, r_k, r_back;

  logic [SW-1:0]    base, rd_sample;
  logic             warm, commit, pass;
  logic             dec_hdr, dec_smp, dec_end;
  logic [PRE_W-1:0] dec_npre;
  logic [TS_W-1:0]  ts_now;
  logic [SW+1:0]    diff;
  logic [SW:0]      mag;

  assign in_ready = (st == ST_IDLE);
  assign commit   = in_valid && in_ready;
  assign r_back   = r_npre - r_k;

  always_comb begin
    diff = {2'b00, in_sample} - {2'b00, base};
    mag  = diff[SW+1] ? (SW+1)'(-diff) : (SW+1)'(diff);
    pass = warm && (mag > {1'b0, cfg_thresh});
  end

  zs_baseline #(
    .NCH(NCH), .CH_W(CH_W), .SW(SW), .WIN(WIN), .PRE_W(PRE_W), .SUM_W(SUM_W)
  ) u_base (
    .clk         (clk),
    .rst_n       (rst_n),
    .chan        (in_chan),
    .base        (base),
    .warm_done   (warm),
    .push        (commit && !pass),
    .push_chan   (in_chan),
    .push_sample (in_sample),
    .rd_chan     (r_chan),
    .rd_back     (r_back),
    .rd_sample   (rd_sample)
  );

  zs_region_ctl #(
    .NCH(NCH), .CH_W(CH_W), .TS_W(TS_W), .PRE_W(PRE_W), .POST_W(POST_W),
    .PRE_MAX(PRE_MAX)
  ) u_region (
    .clk      (clk),
    .rst_n    (rst_n),
    .chan     (in_chan),
    .commit   (commit),
    .warm     (warm),
    .pass     (pass),
    .cfg_pre  (cfg_pre),
    .cfg_post (cfg_post),
    .dec_hdr  (dec_hdr),
    .dec_smp  (dec_smp),
    .dec_end  (dec_end),
    .dec_npre (dec_npre),
    .ts_now   (ts_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      r_chan   <= '0;
      r_ts     <= '0;
      r_sample <= '0;
      r_npre   <= '0;
      r_k      <= '0;
    end else begin
      case (st)
        ST_IDLE: if (commit) begin
          r_chan   <= in_chan;
          r_ts     <= ts_now;
          r_sample <= in_sample;
          r_npre   <= dec_npre;
          r_k      <= '0;
          if (dec_hdr)      st <= ST_HDR;
          else if (dec_smp) st <= ST_SMP;
          else if (dec_end) st <= ST_END;
        end
        ST_HDR: if (out_ready) st <= (r_npre != '0) ? ST_PRE : ST_SMP;
        ST_PRE: if (out_ready) begin
          if (PRE_W'(r_k + 1'b1) == r_npre) st <= ST_SMP;
          else r_k <= r_k + 1'b1;
        end
        ST_SMP, ST_END: if (out_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    out_valid = (st != ST_IDLE);
    out_chan  = r_chan;
    out_kind  = KIND_HDR;
    out_ts    = '0;
    out_data  = '0;
    case (st)
      ST_HDR: out_ts = r_ts - TS_W'(r_npre);
      ST_PRE: begin
        out_kind = KIND_SMP;
        out_ts   = r_ts - TS_W'(r_back);
        out_data = rd_sample;
      end
      ST_SMP: begin
        out_kind = KIND_SMP;
        out_ts   = r_ts;
        out_data = r_sample;
      end
      ST_END: begin
        out_kind = KIND_END;
        out_ts   = r_ts - 1'b1;
      end
      default: ;
    endcase
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_kind) && $stable(out_ts)
                                  && $stable(out_data) && $stable(out_chan));
  assert_hdr_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_kind == KIND_HDR) |=>
      out_valid && out_kind == KIND_SMP && $stable(out_chan));
endmodule

// File: tb/zs_dyn_suppress_bench.sv
`timescale 1ns/1ps
module zs_dyn_suppress_bench;
  localparam int NCH = 4, CH_W = 2, SW = 12, WIN = 192, TS_W = 32, PRE_W = 4, POST_W = 4;
  localparam int SH = 24;
  localparam longint KB = ((longint'(1) << SH) + WIN - 1) / WIN;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [SW-1:0] cfg_thresh;
  logic [PRE_W-1:0] cfg_pre;
  logic [POST_W-1:0] cfg_post;
  logic in_valid = 1'b0, in_ready;
  logic [CH_W-1:0] in_chan = '0;
  logic [SW-1:0] in_sample = '0;
  logic out_valid, out_ready = 1'b1;
  logic [1:0] out_kind;
  logic [CH_W-1:0] out_chan;
  logic [TS_W-1:0] out_ts;
  logic [SW-1:0] out_data;

  always #2.5 clk = ~clk;

  zs_dyn_suppress u_zs_dyn_suppress (
    .clk(clk), .rst_n(rst_n), .cfg_thresh(cfg_thresh), .cfg_pre(cfg_pre),
    .cfg_post(cfg_post), .in_valid(in_valid), .in_ready(in_ready),
    .in_chan(in_chan), .in_sample(in_sample), .out_valid(out_valid),
    .out_ready(out_ready), .out_kind(out_kind), .out_chan(out_chan),
    .out_ts(out_ts), .out_data(out_data)
  );

  typedef logic [57:0] word_t;
  word_t expq[$];
  string tagq[$];
  int total = 0, bad = 0, got_cnt = 0;
  string cur_req = "R1";
  bit bp_on = 0;
  int cyc = 0;

  // reference model state
  int thr = 30, pre = 7, post = 8;
  int wbuf[NCH][WIN];
  int wptr[NCH], wfill[NCH], tsc[NCH], tail[NCH], pcnt[NCH];
  longint bsum[NCH];
  bit act[NCH];

  function automatic word_t mk(int kind, int ch, int ts, int data);
    return {2'(kind), 8'(ch), 32'(ts), 16'(data)};
  endfunction

  task automatic chk(bit ok, string req, string what, longint actv, longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, actv, expv);
    end
  endtask

  task automatic expw(word_t w);
    expq.push_back(w);
    tagq.push_back(cur_req);
  endtask

  task automatic push_win(int ch, int s);
    if (wfill[ch] == WIN) bsum[ch] -= wbuf[ch][wptr[ch]];
    else wfill[ch]++;
    wbuf[ch][wptr[ch]] = s;
    bsum[ch] += s;
    wptr[ch] = (wptr[ch] + 1) % WIN;
  endtask

  task automatic model(int ch, int s);
    int t, base, d, n;
    bit pass;
    t = tsc[ch];
    tsc[ch]++;
    if (wfill[ch] < WIN) begin            // R2 warm-up
      push_win(ch, s);
      if (pcnt[ch] < 15) pcnt[ch]++;
      return;
    end
    base = int'((bsum[ch] * KB) >>> SH);  // R1
    d = s - base;
    pass = (d > thr) || (-d > thr);       // R3
    if (act[ch]) begin
      if (pass) begin expw(mk(1, ch, t, s)); tail[ch] = post; end
      else if (tail[ch] > 0) begin expw(mk(1, ch, t, s)); tail[ch]--; push_win(ch, s); end
      else begin expw(mk(2, ch, t - 1, 0)); act[ch] = 0; pcnt[ch] = 1; push_win(ch, s); end
    end else if (pass) begin
      n = (pcnt[ch] < pre) ? pcnt[ch] : pre;
      expw(mk(0, ch, t - n, 0));
      for (int k = n; k >= 1; k--) expw(mk(1, ch, t - k, wbuf[ch][(wptr[ch] - k + WIN) % WIN]));
      expw(mk(1, ch, t, s));
      act[ch] = 1; tail[ch] = post; pcnt[ch] = 0;
    end else begin
      push_win(ch, s);
      if (pcnt[ch] < 15) pcnt[ch]++;
    end
  endtask

  task automatic set_cfg(int t, int p, int q);
    thr = t; pre = p; post = q;
    @(negedge clk);
    cfg_thresh = SW'(t); cfg_pre = PRE_W'(p); cfg_post = POST_W'(q);
  endtask

  task automatic send(int ch, int s);
    model(ch, s);
    @(negedge clk);
    in_valid = 1'b1; in_chan = CH_W'(ch); in_sample = SW'(s);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic quiet(int ch, int v, int n);
    for (int i = 0; i < n; i++) send(ch, v);
  endtask

  // monitor / scoreboard
  bit hold_pend = 0;
  word_t held;
  always @(negedge clk) begin
    word_t got, e;
    string tg;
    cyc++;
    if (rst_n) begin
      got = {out_kind, 8'(out_chan), out_ts, 16'(out_data)};
      if (hold_pend) chk(out_valid && got == held, "R9", "word held under back-pressure", got, held);
      out_ready = !bp_on || (cyc % 3 != 0);
      if (out_valid && out_ready) begin
        got_cnt++;
        if (expq.size() == 0) chk(0, "R2", "unexpected output word", got, 0);
        else begin
          e = expq.pop_front();
          tg = tagq.pop_front();
          chk(got == e, tg, "output word", got, e);
        end
      end
      hold_pend = out_valid && !out_ready;
      held = got;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R9", "watchdog expired", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  int bases[NCH] = '{2000, 500, 3000, 100};

  initial begin
    for (int c = 0; c < NCH; c++) begin
      wptr[c] = 0; wfill[c] = 0; tsc[c] = 0; tail[c] = 0; pcnt[c] = 0; bsum[c] = 0; act[c] = 0;
    end
    cfg_thresh = SW'(30); cfg_pre = PRE_W'(7); cfg_post = POST_W'(8);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R9", "in_ready after reset", in_ready, 1);
    chk(out_valid == 1'b0, "R9", "out_valid after reset", out_valid, 0);

    // R2 warm-up, all channels interleaved
    cur_req = "R2";
    for (int i = 0; i < WIN; i++)
      for (int c = 0; c < NCH; c++) send(c, bases[c]);
    repeat (5) @(negedge clk);
    chk(got_cnt == 0, "R2", "no output during warm-up", got_cnt, 0);

    // R1/R3: equal to threshold in both signs, then one count over
    cur_req = "R3";
    send(0, 2030); send(0, 1970);
    chk(got_cnt == 0, "R3", "deviation equal to threshold not flagged", got_cnt, 0);
    cur_req = "R1";
    send(0, 2031);
    cur_req = "R6";
    quiet(0, 2000, 10);

    // R3 negative polarity, R7 end marker
    cur_req = "R7";
    send(1, 459); quiet(1, 500, 12);

    // R6 merge inside tail
    cur_req = "R6";
    send(2, 3100); quiet(2, 3000, 3); send(2, 3100); quiet(2, 3000, 12);
    // R5 shortened pre count
    cur_req = "R5";
    quiet(2, 3000, 2); send(2, 3100); quiet(2, 3000, 12);

    // R4 long pulse does not move baseline
    cur_req = "R4";
    quiet(3, 600, 30); quiet(3, 100, 12); send(3, 131); quiet(3, 100, 12);

    // R10/R8 interleaved channels
    cur_req = "R10";
    for (int i = 0; i < 20; i++) begin
      send(0, (i == 3) ? 2100 : 2000);
      send(1, (i == 5) ? 400 : 500);
    end

    // R6 with post 0 and short pre; R3 with raised threshold
    cur_req = "R8";
    set_cfg(30, 2, 0);
    quiet(0, 2000, 3); send(0, 2060); send(0, 2060); quiet(0, 2000, 3);
    set_cfg(100, 7, 8);
    cur_req = "R3";
    send(0, 2060); quiet(0, 2000, 2);
    set_cfg(30, 7, 8);

    // R9 back-pressure
    cur_req = "R9";
    bp_on = 1;
    send(1, 600); quiet(1, 500, 12);
    send(3, 40); send(2, 2900); quiet(3, 100, 10); quiet(2, 3000, 10);
    repeat (60) @(negedge clk);
    bp_on = 0;

    repeat (60) @(negedge clk);
    chk(expq.size() == 0, "R7", "all expected words delivered", expq.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule